// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This unit lets the CPUs of a cluster interrupt one another and themselves. A store to the send register raises an "other" interrupt on every CPU whose bit is set in the data, and can also raise a "self" interrupt on the CPU that makes the store. Each CPU has two pending flags ("other" and "self") and one mask flag for each. A CPU's request line is high while at least one of its flags is pending and not masked.

Software reads a per-CPU event register to learn what fired. The word uses the same type/number layout as hardware interrupt events: the type is in the upper half and the number is in the lower half. Reading an event masks the kind that was reported, so the handler acknowledges it and then unmasks it again. Hardware interrupts come first. While the arbiter reports a hardware event pending for a CPU, this unit returns an empty word and changes nothing.

There are two ways to reach the registers. A CPU-relative view at 0x2000 acts on the CPU identified by `bus_cpu`. Absolute windows at 0x5000 + (cpu << 7) act on an explicitly named CPU, whoever is accessing.

Top module: `ipi_unit`

## Requirements
- R1: After reset, every pending flag is clear and both mask flags are set on every CPU. As a result, `ipi_req` is all zero and a mask read returns 0x80000001.
- R2: A write to 0x2008 sets the "other" pending flag of each CPU c < NCPU whose data bit c is one. Data bit 31 sets the "self" pending flag of the accessing CPU.
- R3: A write to the acknowledge register clears the pending flags selected by data bit 0 ("other") and data bit 31 ("self"). The register is at 0x200c, or at 0x500c + (cpu << 7) in the windows. Data bits that are zero leave their flag unchanged. A read of the register returns the pending flags in those same bit positions.
- R4: A write to mask-set (0x2024 / 0x5024 + (cpu << 7)) sets the selected masks. A write to mask-clear (0x2028 / 0x5028 + (cpu << 7)) clears them. Both use the bit 0 / bit 31 layout, and reading either register returns the masks in that layout.
- R5: `ipi_req[c]` is high on the cycle after a write that leaves CPU c with a pending flag that is not masked. It is low when no such flag remains.
- R6: A read of 0x2004 returns 0x00040001 when "other" is pending and not masked. When only "self" is in that state, it returns 0x00040002. When neither is, it returns 0. "Other" is reported first when both are in that state.
- R7: An event read that reports a kind sets the mask of that kind on the accessing CPU. The pending flag is left as it is.
- R8: While `hw_pend` is high for the accessing CPU, an event read returns 0 and masks nothing.
- R9: A read of 0x2000 returns the index on `bus_cpu`.
- R10: A write to 0x5008 + (cpu << 7) sets the pending flags selected by bit 0 and bit 31 on that CPU. Window accesses to a CPU index of NCPU or higher have no effect.
- R11: Every read returns its data on `rd_data`, with `rd_valid` high, in the cycle after it is presented. `rd_valid` is low in the cycle after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | 5 | Index of the accessing CPU |
| hw_pend | input | NCPU | Hardware event pending per CPU (from arbiter) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| ipi_req | output | NCPU | Interrupt request per CPU |
| ipi_evt | output | 32*NCPU | Current event word per CPU for the arbiter |

## Verification
A write changes the flag registers at the clock edge that samples it. `ipi_req` and every later read therefore show the new state one cycle after the write. Read data, including the auto-mask caused by an event read, appears one cycle after the read is presented.

The bench changes inputs on the falling edge and presents every access for exactly one rising edge. It samples `rd_data`, `rd_valid` and `ipi_req` at the falling edge that follows, which is exactly the cycle in which each result is due. Flag state that cannot be seen on a port is read back through the pending and mask registers.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int CPU_IDW = 5;
  localparam logic [15:0] EVT_TYPE_IPI = 16'd4;
  localparam logic [15:0] EVT_NUM_OTH  = 16'd1;
  localparam logic [15:0] EVT_NUM_SELF = 16'd2;

  // bit 0 = "other", bit 1 = "self"
  typedef logic [1:0] kind_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_WHO, OP_EVT, OP_SEND, OP_ACK, OP_PSET, OP_MSET, OP_MCLR
  } op_e;

  // data word bit 0 / bit 31 -> kind vector
  function automatic kind_t word_to_kind(logic [31:0] w);
    return {w[31], w[0]};
  endfunction

  function automatic logic [31:0] kind_to_word(kind_t k);
    return {k[1], 30'b0, k[0]};
  endfunction

  // "other" wins over "self"
  function automatic kind_t pick_first(kind_t f);
    if (f[0]) return 2'b01;
    if (f[1]) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [31:0] evt_word(kind_t f);
    kind_t p;
    p = pick_first(f);
    if (p[0]) return {EVT_TYPE_IPI, EVT_NUM_OTH};
    if (p[1]) return {EVT_TYPE_IPI, EVT_NUM_SELF};
    return 32'd0;
  endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic [15:0]        addr,
  input  logic [CPU_IDW-1:0] cpu,
  output op_e                op,
  output logic [CPU_IDW-1:0] tgt,
  output logic               tgt_ok
);
  always_comb begin
    op     = OP_NONE;
    tgt    = cpu;
    tgt_ok = (int'(cpu) < NCPU);
    if (addr[15:12] == 4'h2 && addr[11:7] == 5'd0) begin
      case (addr[6:0])
        7'h00:   op = OP_WHO;
        7'h04:   op = OP_EVT;
        7'h08:   op = OP_SEND;
        7'h0c:   op = OP_ACK;
        7'h24:   op = OP_MSET;
        7'h28:   op = OP_MCLR;
        default: op = OP_NONE;
      endcase
    end else if (addr[15:12] == 4'h5) begin
      tgt    = addr[11:7];
      tgt_ok = (int'(addr[11:7]) < NCPU);
      case (addr[6:0])
        7'h08:   op = OP_PSET;
        7'h0c:   op = OP_ACK;
        7'h24:   op = OP_MSET;
        7'h28:   op = OP_MCLR;
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ipi_cpu_slice.sv
module ipi_cpu_slice
  import ipi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  kind_t set_k,
  input  kind_t clr_k,
  input  kind_t mset_k,
  input  kind_t mclr_k,
  output kind_t pend_q,
  output kind_t mask_q,
  output kind_t fire,
  output logic  req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 2'b00;
      mask_q <= 2'b11;
    end else begin
      pend_q <= (pend_q | set_k) & ~clr_k;
      mask_q <= (mask_q | mset_k) & ~mclr_k;
    end
  end

  assign fire = pend_q & ~mask_q;
  assign req  = |fire;
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [15:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [4:0]           bus_cpu,
  input  logic [NCPU-1:0]      hw_pend,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  output logic [NCPU-1:0]      ipi_req,
  output logic [NCPU*32-1:0]   ipi_evt
);
  localparam int EVT_W = 32;

  op_e               op;
  logic [CPU_IDW-1:0] tgt;
  logic              tgt_ok;

  ipi_decode #(.NCPU(NCPU)) u_dec (
    .addr(bus_addr), .cpu(bus_cpu), .op(op), .tgt(tgt), .tgt_ok(tgt_ok)
  );

  logic wr, rd;
  assign wr = bus_valid && bus_write;
  assign rd = bus_valid && !bus_write;

  kind_t wkind;
  assign wkind = word_to_kind(bus_wdata);

  // one-hot selection of the addressed CPU
  logic [NCPU-1:0] sel;
  kind_t pend_q [NCPU];
  kind_t mask_q [NCPU];
  kind_t fire   [NCPU];
  kind_t pend_sel, mask_sel, fire_sel;
  logic  hw_sel;

  always_comb begin
    pend_sel = '0;
    mask_sel = '0;
    fire_sel = '0;
    hw_sel   = 1'b0;
    for (int i = 0; i < NCPU; i++) begin
      sel[i] = tgt_ok && (tgt == CPU_IDW'(i));
      if (sel[i]) begin
        pend_sel = pend_q[i];
        mask_sel = mask_q[i];
        fire_sel = fire[i];
        hw_sel   = hw_pend[i];
      end
    end
  end

  // named internal events
  logic            evt_take;
  logic            evt_blocked;
  kind_t           take_kind;
  logic [NCPU-1:0] send_oth_vec;
  logic [NCPU-1:0] ack_oth_vec;
  logic [NCPU-1:0] take_oth_vec;
  logic [NCPU-1:0] pend_oth;
  logic [NCPU-1:0] mask_oth;

  assign evt_blocked = rd && op == OP_EVT && tgt_ok && hw_sel;
  assign evt_take    = rd && op == OP_EVT && tgt_ok && !hw_sel && (fire_sel != 2'b00);
  assign take_kind   = evt_take ? pick_first(fire_sel) : 2'b00;

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    kind_t set_k, clr_k, mset_k, mclr_k, take_k;
    logic  send_self;

    assign send_self = wr && op == OP_SEND && sel[i] && bus_wdata[31];
    assign send_oth_vec[i] = wr && op == OP_SEND && bus_wdata[i];
    assign set_k  = {send_self, send_oth_vec[i]}
                  | ((wr && op == OP_PSET && sel[i]) ? wkind : 2'b00);
    assign clr_k  = (wr && op == OP_ACK  && sel[i]) ? wkind : 2'b00;
    assign take_k = sel[i] ? take_kind : 2'b00;
    assign mset_k = ((wr && op == OP_MSET && sel[i]) ? wkind : 2'b00) | take_k;
    assign mclr_k = (wr && op == OP_MCLR && sel[i]) ? wkind : 2'b00;

    ipi_cpu_slice u_slice (
      .clk(clk), .rst_n(rst_n),
      .set_k(set_k), .clr_k(clr_k), .mset_k(mset_k), .mclr_k(mclr_k),
      .pend_q(pend_q[i]), .mask_q(mask_q[i]), .fire(fire[i]), .req(ipi_req[i])
    );

    assign ack_oth_vec[i]  = clr_k[0];
    assign take_oth_vec[i] = take_k[0];
    assign pend_oth[i]     = pend_q[i][0];
    assign mask_oth[i]     = mask_q[i][0];
    assign ipi_evt[i*EVT_W +: EVT_W] = evt_word(fire[i]);
  end

  // read mux, registered
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = 32'd0;
    case (op)
      OP_WHO:          rd_mux = {{(32-CPU_IDW){1'b0}}, bus_cpu};
      OP_EVT:          rd_mux = (tgt_ok && !hw_sel) ? evt_word(fire_sel) : 32'd0;
      OP_ACK, OP_PSET: rd_mux = tgt_ok ? kind_to_word(pend_sel) : 32'd0;
      OP_MSET, OP_MCLR: rd_mux = tgt_ok ? kind_to_word(mask_sel) : 32'd0;
      default:         rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 32'd0;
    end else begin
      rd_valid <= rd;
      rd_data  <= rd ? rd_mux : 32'd0;
    end
  end
endmodule

// File: rtl/ipi_unit_checker.sv
module ipi_unit_checker #(
  parameter int NCPU = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [15:0]       bus_addr,
  input logic [4:0]        bus_cpu,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic [NCPU-1:0]   ipi_req,
  input logic [NCPU-1:0]   pend_oth,
  input logic [NCPU-1:0]   mask_oth,
  input logic [NCPU-1:0]   send_oth_vec,
  input logic [NCPU-1:0]   ack_oth_vec,
  input logic [NCPU-1:0]   take_oth_vec,
  input logic              evt_blocked
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (ipi_req == '0 && pend_oth == '0 && mask_oth == '1));

  p_send_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (send_oth_vec != '0) |=> ((pend_oth & $past(send_oth_vec)) == $past(send_oth_vec)));

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oth_vec != '0) |=> ((pend_oth & $past(ack_oth_vec)) == '0));

  p_evt_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_data[31:16] == 16'd4) |-> (rd_data[15:0] == 16'd1 || rd_data[15:0] == 16'd2));

  p_auto_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_oth_vec != '0) |=> ((mask_oth & $past(take_oth_vec)) == $past(take_oth_vec)));

  p_hw_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_blocked |=> (rd_data == 32'd0));

  p_whoami_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == 16'h2000) |=> (rd_data == {27'd0, $past(bus_cpu)}));

  p_rd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);

  p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rd_valid);
endmodule

bind ipi_unit ipi_unit_checker #(.NCPU(NCPU)) u_chk (.*);

// File: tb/ipi_unit_bench.sv
module ipi_unit_bench;
  localparam int NCPU = 4;
  localparam time CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [15:0]       bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [4:0]        bus_cpu = '0;
  logic [NCPU-1:0]   hw_pend = '0;
  logic              rd_valid;
  logic [31:0]       rd_data;
  logic [NCPU-1:0]   ipi_req;
  logic [NCPU*32-1:0] ipi_evt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ipi_unit #(.NCPU(NCPU)) u_ipi_unit (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .hw_pend(hw_pend), .rd_valid(rd_valid), .rd_data(rd_data),
    .ipi_req(ipi_req), .ipi_evt(ipi_evt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [4:0] c);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_cpu = c;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [4:0] c, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_cpu = c;
    @(negedge clk);
    bus_valid = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 req after reset", 32'(ipi_req), 32'h0);
    rd(16'h2024, 5'd0, d); chk("R1 masks after reset", d, 32'h80000001);
    rd(16'h200c, 5'd3, d); chk("R1 pending after reset", d, 32'h0);
  endtask

  task automatic t_send();
    logic [31:0] d;
    for (int c = 0; c < NCPU; c++) wr(16'h2028, 32'h80000001, 5'(c));
    chk("R4 unmask leaves req low", 32'(ipi_req), 32'h0);
    wr(16'h2008, 32'h00000005, 5'd1);
    chk("R2 R5 send to cpus 0,2", 32'(ipi_req), 32'h5);
    rd(16'h510c, 5'd0, d); chk("R10 window pending cpu2", d, 32'h1);
  endtask

  task automatic t_event();
    logic [31:0] d;
    rd(16'h2004, 5'd0, d); chk("R6 event other", d, 32'h00040001);
    chk("R7 req drops after event", 32'(ipi_req), 32'h4);
    rd(16'h2024, 5'd0, d); chk("R7 other masked", d, 32'h00000001);
    wr(16'h200c, 32'h1, 5'd0);
    rd(16'h200c, 5'd0, d); chk("R3 ack clears", d, 32'h0);
    wr(16'h200c, 32'h0, 5'd2);
    rd(16'h200c, 5'd2, d); chk("R3 zero ack no effect", d, 32'h1);
  endtask

  task automatic t_mask();
    wr(16'h2024, 32'h1, 5'd2);
    chk("R4 mask set hides", 32'(ipi_req), 32'h0);
    wr(16'h2028, 32'h1, 5'd2);
    chk("R4 mask clr restores", 32'(ipi_req), 32'h4);
  endtask

  task automatic t_order();
    logic [31:0] d;
    wr(16'h2008, 32'h80000000, 5'd2);
    rd(16'h2004, 5'd2, d); chk("R6 other first", d, 32'h00040001);
    rd(16'h2004, 5'd2, d); chk("R6 then self", d, 32'h00040002);
    rd(16'h2004, 5'd2, d); chk("R7 both masked, empty", d, 32'h0);
    chk("R5 req low when masked", 32'(ipi_req), 32'h0);
  endtask

  task automatic t_hw();
    logic [31:0] d;
    wr(16'h5188, 32'h1, 5'd0);
    chk("R10 window set cpu3", 32'(ipi_req), 32'h8);
    hw_pend = 4'b1000;
    rd(16'h2004, 5'd3, d); chk("R8 hw wins", d, 32'h0);
    chk("R8 no auto-mask", 32'(ipi_req), 32'h8);
    hw_pend = 4'b0000;
    rd(16'h2004, 5'd3, d); chk("R6 event after hw", d, 32'h00040001);
    chk("R7 req3 drops", 32'(ipi_req), 32'h0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    wr(16'h50a4, 32'h80000001, 5'd0);
    rd(16'h2024, 5'd1, d); chk("R10 window mask cpu1", d, 32'h80000001);
    wr(16'h50a8, 32'h80000000, 5'd3);
    rd(16'h2028, 5'd1, d); chk("R4 window mask clr self", d, 32'h00000001);
    wr(16'h5288, 32'h80000001, 5'd0);
    chk("R10 out-of-range cpu ignored", 32'(ipi_req), 32'h0);
    rd(16'h5288, 5'd0, d); chk("R10 out-of-range reads zero", d, 32'h0);
  endtask

  task automatic t_who();
    logic [31:0] d;
    rd(16'h2000, 5'd3, d); chk("R9 whoami", d, 32'h3);
    chk("R11 rd_valid on read", 32'(rd_valid), 32'h1);
    @(negedge clk);
    chk("R11 rd_valid idle", 32'(rd_valid), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_send();
    t_event();
    t_mask();
    t_order();
    t_hw();
    t_window();
    t_who();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule